// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the bus timing strobes of an 8-bit controller core for external memory. It runs on the oscillator clock and divides it into machine cycles of twelve periods, with each machine cycle split into two halves of six periods. In every half it pulses the address latch strobe. When code is fetched from outside the chip, it also drives an active-low program read strobe after the latch strobe has ended.

A code fetch goes to internal memory only while the external-access pin is high and the program counter is at or below the top of the on-chip code space. In every other case the fetch is external. A request for an external data transfer is taken once per machine cycle. The next machine cycle then becomes a data cycle. In a data cycle, the latch strobe of the second half and both program read strobes are suppressed, and a single read or write strobe fills that window, selected by the direction of the transfer.

Top module: `bus_strobe_seq`

## Requirements
- R1: While rstN is low, ale is 0, psenN, rdN and wrN are 1, and extFetch is 0.
- R2: The rising clock edges after reset release are numbered from 0. After an edge whose number modulo 12 is 1, 2, 7 or 8, ale is 1. After every other edge it is 0, except as R7 states.
- R3: In a code cycle, psenN is 0 after edges whose number modulo 12 is 3, 4, 5, 9, 10 or 11, provided extFetch is 1. So psenN is never low while ale is high.
- R4: At edges whose number modulo 6 is 0, extFetch is loaded with 1 if eaPin is 0 or pc is greater than 0x3FFF, and with 0 otherwise. It holds its value between those edges.
- R5: psenN stays 1 for the whole half cycle while extFetch is 0.
- R6: xdatReq is sampled at edges whose number modulo 12 is 11. If it is 1, the twelve edges that follow form a data cycle.
- R7: In a data cycle, ale pulses only in the first half (after edges 1 and 2 modulo 12).
- R8: In a data cycle, psenN stays 1. The transfer strobe is low after the edges numbered 3 through 11 modulo 12 (nine periods).
- R9: The transfer strobe is wrN if xdatWrite was 1 when the request was sampled, and rdN otherwise. The two are never low together.
- R10: xdatReq has no effect at any edge other than the sampling edge of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pc | input | 16 | Program counter of the next fetch |
| eaPin | input | 1 | External-access pin level |
| xdatReq | input | 1 | Request for an external data cycle |
| xdatWrite | input | 1 | Direction of the requested transfer, 1 = write |
| ale | output | 1 | Address latch strobe |
| psenN | output | 1 | Program read strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| extFetch | output | 1 | Current fetch is from external code memory |

## Verification
Every strobe is registered, so each one changes one clock after the phase counter has reached the matching position. extFetch follows pc and eaPin one clock after a half-cycle boundary edge. A data request takes effect one clock after the last edge of its machine cycle. The reference model in the bench updates its expected values at the same rising edge the design uses. The bench compares all five outputs on the following falling edge. Inputs change only on falling edges, so the design and the model always sample the same values.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  // Per-cycle slot decode handed from control to datapath
  typedef struct packed {
    logic aleSlot;     // latch strobe window
    logic codeSlot;    // program read window (if external)
    logic readSlot;    // data read window
    logic writeSlot;   // data write window
    logic sampleSel;   // half-cycle boundary: re-evaluate fetch source
  } strobeT;
endpackage

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
#(
  parameter int HALF_LEN  = 6,
  parameter int ALE_FIRST = 1,
  parameter int ALE_WIDTH = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   xdatReq,
  input  logic   xdatWrite,
  output strobeT strobes
);
  localparam int CYCLE_LEN  = 2 * HALF_LEN;
  localparam int PW         = $clog2(CYCLE_LEN);
  localparam int CODE_FIRST = ALE_FIRST + ALE_WIDTH;
  localparam logic [PW-1:0] LAST_P  = PW'(CYCLE_LEN - 1);
  localparam logic [PW-1:0] HALF_P  = PW'(HALF_LEN);
  localparam logic [PW-1:0] ALE_P   = PW'(ALE_FIRST);
  localparam logic [PW-1:0] CODE_P  = PW'(CODE_FIRST);
  localparam logic [PW-1:0] ONE_P   = PW'(1);
  localparam logic [PW-1:0] ZERO_P  = '0;

  logic [PW-1:0] phaseQ;
  logic          dataCycQ;
  logic          writeQ;
  logic [PW-1:0] subPhase;
  logic          secondHalf;
  logic          dataWin;

  // Machine-cycle phase counter and data-cycle latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= ZERO_P;
      dataCycQ <= 1'b0;
      writeQ   <= 1'b0;
    end else begin
      if (phaseQ == LAST_P) begin
        phaseQ   <= ZERO_P;
        dataCycQ <= xdatReq;
        writeQ   <= xdatWrite;
      end else begin
        phaseQ <= phaseQ + ONE_P;
      end
    end
  end

  always_comb begin
    secondHalf = (phaseQ >= HALF_P);
    subPhase   = secondHalf ? (phaseQ - HALF_P) : phaseQ;
    dataWin    = dataCycQ && (phaseQ >= CODE_P);

    strobes.aleSlot   = (subPhase >= ALE_P) && (subPhase < CODE_P)
                        && !(dataCycQ && secondHalf);
    strobes.codeSlot  = (subPhase >= CODE_P) && !dataCycQ;
    strobes.readSlot  = dataWin && !writeQ;
    strobes.writeSlot = dataWin && writeQ;
    strobes.sampleSel = (subPhase == ZERO_P);
  end
endmodule

// File: rtl/bus_seq_dpath.sv
module bus_seq_dpath
  import bus_seq_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CODE_TOP = 16'h3FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [ADDR_W-1:0] pc,
  input  logic              eaPin,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic              extFetch
);
  logic fetchExtQ;
  logic wantExt;

  assign wantExt = !eaPin || (pc > CODE_TOP);

  // Fetch source is re-evaluated once per half cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  fetchExtQ <= 1'b0;
    else if (strobes.sampleSel) fetchExtQ <= wantExt;
  end

  // Registered pin drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ale   <= 1'b0;
      psenN <= 1'b1;
      rdN   <= 1'b1;
      wrN   <= 1'b1;
    end else begin
      ale   <= strobes.aleSlot;
      psenN <= !(strobes.codeSlot && fetchExtQ);
      rdN   <= !strobes.readSlot;
      wrN   <= !strobes.writeSlot;
    end
  end

  assign extFetch = fetchExtQ;
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bus_seq_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CODE_TOP  = 16'h3FFF,
  parameter int              HALF_LEN  = 6,
  parameter int              ALE_FIRST = 1,
  parameter int              ALE_WIDTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] pc,
  input  logic              eaPin,
  input  logic              xdatReq,
  input  logic              xdatWrite,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic              extFetch
);
  strobeT strobes;

  bus_seq_ctrl #(
    .HALF_LEN (HALF_LEN),
    .ALE_FIRST(ALE_FIRST),
    .ALE_WIDTH(ALE_WIDTH)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .xdatReq  (xdatReq),
    .xdatWrite(xdatWrite),
    .strobes  (strobes)
  );

  bus_seq_dpath #(
    .ADDR_W  (ADDR_W),
    .CODE_TOP(CODE_TOP)
  ) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pc      (pc),
    .eaPin   (eaPin),
    .ale     (ale),
    .psenN   (psenN),
    .rdN     (rdN),
    .wrN     (wrN),
    .extFetch(extFetch)
  );
endmodule

// File: rtl/bus_strobe_chk.sv
module bus_strobe_chk (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic psenN,
  input logic rdN,
  input logic wrN,
  input logic extFetch
);
  // R9: read and write strobes are exclusive
  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R3: program read never overlaps the latch strobe
  assert_psen_after_ale_R3: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> psenN);

  // R5: program read only when the fetch source was external
  assert_psen_internal_R5: assert property (@(posedge clk) disable iff (!rstN)
    !psenN |-> $past(extFetch));

  // R8: transfer strobe excludes program read and latch strobe
  assert_data_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> (psenN && !ale));

  // R2: latch strobe is exactly two periods wide
  assert_ale_min_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ale) |=> ale);
  assert_ale_max_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ale && $past(ale)) |=> !ale);
endmodule

bind bus_strobe_seq bus_strobe_chk i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ale     (ale),
  .psenN   (psenN),
  .rdN     (rdN),
  .wrN     (wrN),
  .extFetch(extFetch)
);

// File: tb/test_bus_strobe_seq.sv
`timescale 1ns/1ps
module test_bus_strobe_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pc = 16'h0000;
  logic        eaPin = 1'b1;
  logic        xdatReq = 1'b0;
  logic        xdatWrite = 1'b0;
  logic        ale, psenN, rdN, wrN, extFetch;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_strobe_seq i_bus_strobe_seq (
    .clk(clk), .rstN(rstN), .pc(pc), .eaPin(eaPin),
    .xdatReq(xdatReq), .xdatWrite(xdatWrite),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN), .extFetch(extFetch)
  );

  // Behavioural reference: edge counter modulo 12 and cycle flags
  int mph;
  bit mData, mWrite, mExt;
  bit eAle, ePsenN, eRdN, eWrN, eExt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mph = 0; mData = 0; mWrite = 0; mExt = 0;
      eAle = 0; ePsenN = 1; eRdN = 1; eWrN = 1; eExt = 0;
    end else begin
      int sub;
      bit hi;
      sub = mph % 6;
      hi  = (mph >= 6);
      eAle   = (sub == 1 || sub == 2) && !(mData && hi);
      ePsenN = !(mExt && sub >= 3 && !mData);
      eRdN   = !(mData && !mWrite && mph >= 3);
      eWrN   = !(mData && mWrite && mph >= 3);
      if (sub == 0) mExt = !eaPin || (pc > 16'h3FFF);
      eExt = mExt;
      if (mph == 11) begin mData = xdatReq; mWrite = xdatWrite; end
      mph = (mph + 1) % 12;
    end
  end

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check1("R2 R7 ale",        ale,      eAle);
      check1("R3 R5 R8 psenN",   psenN,    ePsenN);
      check1("R6 R8 R9 rdN",     rdN,      eRdN);
      check1("R9 R10 wrN",       wrN,      eWrN);
      check1("R4 extFetch",      extFetch, eExt);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int lowCount;
    // R1: reset state
    idle(3);
    check1("R1 ale",      ale,      1'b0);
    check1("R1 psenN",    psenN,    1'b1);
    check1("R1 rdN",      rdN,      1'b1);
    check1("R1 wrN",      wrN,      1'b1);
    check1("R1 extFetch", extFetch, 1'b0);
    rstN = 1'b1;

    // Internal fetch, then external via pin, then via address
    pc = 16'h0100; eaPin = 1'b1; idle(30);
    eaPin = 1'b0; idle(30);
    eaPin = 1'b1; pc = 16'h3FFF; idle(24);   // R4 boundary: internal
    pc = 16'h4000; idle(24);                 // R4 boundary: external
    pc = 16'hFFFF; idle(13);

    // Read request held one full cycle (R6)
    xdatReq = 1'b1; xdatWrite = 1'b0; idle(12);
    xdatReq = 1'b0; idle(24);
    // Write request
    xdatReq = 1'b1; xdatWrite = 1'b1; idle(12);
    xdatReq = 1'b0; idle(24);
    // Back-to-back data cycles, alternating direction
    for (int k = 0; k < 4; k++) begin
      xdatReq = 1'b1; xdatWrite = k[0]; idle(12);
    end
    xdatReq = 1'b0; idle(24);

    // R10: request pulses everywhere except the sampling edge
    lowCount = 0;
    for (int i = 0; i < 60; i++) begin
      xdatReq = (mph != 11);
      xdatWrite = i[1];
      @(negedge clk);
      if (!rdN || !wrN) lowCount++;
    end
    xdatReq = 1'b0;
    checks++;
    if (lowCount != 0) begin
      errors++;
      $display("FAIL R10 ignored request: actual=%0d strobes expected=0", lowCount);
    end

    // Mixed pattern with fetch source changing
    for (int i = 0; i < 400; i++) begin
      pc = 16'($urandom);
      if (i % 7 == 0) eaPin = ~eaPin;
      xdatReq = ($urandom % 3 == 0);
      xdatWrite = $urandom % 2;
      @(negedge clk);
    end
    xdatReq = 1'b0; idle(24);

    // Reset in the middle of a data cycle (R1)
    xdatReq = 1'b1; idle(16);
    rstN = 1'b0; idle(1);
    check1("R1 mid ale",   ale,   1'b0);
    check1("R1 mid rdN",   rdN,   1'b1);
    check1("R1 mid wrN",   wrN,   1'b1);
    check1("R1 mid psenN", psenN, 1'b1);
    xdatReq = 1'b0; rstN = 1'b1; idle(30);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule